// File: doc/BRIEF.md
# Sound Coprocessor Control-Page Decoder

This block sits between an 8-bit sound processor core and its 64 KiB work memory. Sixteen bytes of the address space, 0x00F0 to 0x00FF, hold the control page. On this page, reads and writes go to local registers: the host mailbox bytes, an indirect window onto a signal-processor register file, timer targets and enables, and the timer tick counters. A small boot image sits at the top of the address space. It overlays the memory for reads until software switches it off.

Writes never stop at the decoder. Every store is also passed unchanged to the memory, including stores to the control page and stores to the boot-image window. A read result appears one cycle after the request. This gives the same latency for the synchronous memory and for the local registers. Reading a tick counter sends a clear pulse to the timer logic.

Top module: `sio_io_decoder`

## Requirements
- R1: After reset, the following values hold. All timer enables, timer targets, mailbox bytes and host-facing bytes are zero. The indirect index is zero. `cpu_rdata` is zero. The boot image is mapped.
- R2: A cycle with `cpu_wr` high drives `ram_we` high, with `ram_addr` and `ram_wdata` equal to `cpu_addr` and `cpu_wdata`. This applies to every address. A cycle with `cpu_rd` high drives `ram_re` high.
- R3: The data for a read issued in one cycle appears on `cpu_rdata` after the next rising edge. It stays there until the next read.
- R4: Reads of 0xF0, 0xF1, 0xFA, 0xFB and 0xFC return 0x00.
- R5: A write to 0xF2 stores the 8-bit indirect index, and a read of 0xF2 returns it. `dsp_idx` always shows the low 7 bits of the index. A read of 0xF3 returns `dsp_rdata`.
- R6: A write to 0xF3 pulses `dsp_we` in the same cycle, with `dsp_wdata` equal to the data. This happens only when bit 7 of the index is 0. Otherwise no pulse is sent.
- R7: The host loads mailbox byte k (k = 0..3, chosen by `host_sel`) with `host_wr`. The processor reads that byte at 0xF4+k. Processor writes to 0xF4+k set byte k of `host_rx` (bits 8k+7:8k) and leave the mailbox unchanged.
- R8: Addresses 0xF8 and 0xF9 are two plain read/write bytes.
- R9: A write to 0xF1 does four things. Bits 2:0 set `tmr_enable[2:0]`. `tmr_restart[i]` pulses in the write cycle when bit i is 1 and the enable was 0. Bit 4 clears mailbox bytes 0 and 1. Bit 5 clears mailbox bytes 2 and 3. If a host write hits a byte in the same cycle, the clear wins.
- R10: Bit 7 of a write to 0xF1 maps the boot image (1) or unmaps it (0). While mapped, a read of 0xFFC0+k returns byte k of `ROM_IMAGE` (bits 8k+7:8k). The default byte k is (37·k + 17) mod 256. While unmapped, the read returns memory data.
- R11: Writes to 0xFA, 0xFB and 0xFC load `tmr_target` bytes 0, 1 and 2 (bits 8i+7:8i). No other write changes the targets.
- R12: A read of 0xFD+i returns `tmr_count_in[4i+3:4i]`, zero-extended. It also pulses `tmr_count_clr[i]` in the request cycle. No other access pulses it.
- R13: All addresses outside the control page and outside the mapped boot window return `ram_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | Processor address |
| cpu_rd | input | 1 | Read request |
| cpu_wr | input | 1 | Write request |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, one cycle after request |
| host_wr | input | 1 | Host mailbox write strobe |
| host_sel | input | 2 | Host mailbox byte select |
| host_wdata | input | 8 | Host mailbox data |
| host_rx | output | 32 | Four bytes written by the processor for the host |
| ram_addr | output | 16 | Memory address |
| ram_re | output | 1 | Memory read enable |
| ram_we | output | 1 | Memory write enable |
| ram_wdata | output | 8 | Memory write data |
| ram_rdata | input | 8 | Memory read data, valid the cycle after `ram_re` |
| dsp_idx | output | 7 | Register index for the signal processor |
| dsp_we | output | 1 | Signal-processor write strobe |
| dsp_wdata | output | 8 | Signal-processor write data |
| dsp_rdata | input | 8 | Signal-processor data at `dsp_idx` |
| tmr_enable | output | 3 | Timer enables |
| tmr_restart | output | 3 | Pulse on an enable rising from 0 to 1 |
| tmr_target | output | 24 | Timer targets, 8 bits each |
| tmr_count_in | input | 12 | Timer tick counters, 4 bits each |
| tmr_count_clr | output | 3 | Counter clear pulse on read |

## Verification
Two situations are hard to reach. The first is a host write and a control-register clear that hit the same mailbox byte in the same cycle. The bench reaches it with a dedicated task. That task raises `host_wr` for byte 2 on the exact cycle of a 0xF1 write with bit 5 set, then reads 0xF6 back to confirm the clear won. The second is the dropped indirect write. It needs a large index latched first. The bench then checks that `dsp_we` stays low during the blocked 0xF3 write, while the data still reaches memory.

// File: rtl/sio_pkg.sv
// Package: constants shared by the control-page decoder.
// Assumes a 16-bit address, an 8-bit data bus and the page at 0x00F0.
package sio_pkg;
    localparam int            ADDR_W       = 16;
    localparam int            DATA_W       = 8;
    localparam logic [11:0]   PAGE_TAG     = 12'h00F;
    localparam logic [3:0]    OFS_CTRL     = 4'h1;
    localparam logic [3:0]    OFS_DSP_IDX  = 4'h2;
    localparam logic [3:0]    OFS_DSP_DATA = 4'h3;
    localparam logic [3:0]    OFS_PORT0    = 4'h4;
    localparam logic [3:0]    OFS_TGT0     = 4'hA;
    localparam logic [3:0]    OFS_CNT0     = 4'hD;
    localparam int            CTL_CLR_LO   = 4;
    localparam int            CTL_CLR_HI   = 5;
    localparam int            CTL_ROM_EN   = 7;
    localparam int            ROM_BYTES_DEF = 64;

    // Default boot image: byte k = 37*k + 17 (mod 256).
    function automatic logic [ROM_BYTES_DEF*8-1:0] rom_default();
        logic [ROM_BYTES_DEF*8-1:0] img;
        img = '0;
        for (int k = 0; k < ROM_BYTES_DEF; k++) begin
            img[k*8 +: 8] = 8'((k * 37 + 17) % 256);
        end
        return img;
    endfunction
endpackage

// File: rtl/sio_ctrl_regs.sv
// Control registers: timer enables/targets, indirect index, overlay switch.
// Assumes NUM_TIMERS <= 3 so enables fit below the clear bits and the
// targets fit between 0xFA and 0xFC.
module sio_ctrl_regs
    import sio_pkg::*;
#(
    parameter int NUM_TIMERS = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr,
    input  logic                    page_hit,
    input  logic [3:0]              lo,
    input  logic [DATA_W-1:0]       wdata,
    output logic [NUM_TIMERS-1:0]   tmr_enable,
    output logic [NUM_TIMERS-1:0]   tmr_restart,
    output logic [NUM_TIMERS*8-1:0] tmr_target,
    output logic [DATA_W-1:0]       dsp_index,
    output logic                    dsp_we,
    output logic                    rom_mapped,
    output logic                    clr_lo,
    output logic                    clr_hi
);
    logic ctl_wr;
    logic page_wr;

    assign page_wr = wr && page_hit;
    assign ctl_wr  = page_wr && (lo == OFS_CTRL);

    // Enable rising edges request a timer restart in the write cycle.
    assign tmr_restart = {NUM_TIMERS{ctl_wr}} & wdata[NUM_TIMERS-1:0] & ~tmr_enable;
    assign clr_lo      = ctl_wr && wdata[CTL_CLR_LO];
    assign clr_hi      = ctl_wr && wdata[CTL_CLR_HI];
    // Indirect writes only reach the lower half of the register file.
    assign dsp_we      = page_wr && (lo == OFS_DSP_DATA) && !dsp_index[DATA_W-1];

    // Control byte: timer enables and overlay switch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_enable <= '0;
            rom_mapped <= 1'b1;
        end else if (ctl_wr) begin
            tmr_enable <= wdata[NUM_TIMERS-1:0];
            rom_mapped <= wdata[CTL_ROM_EN];
        end
    end

    // Indirect register index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dsp_index <= '0;
        end else if (page_wr && (lo == OFS_DSP_IDX)) begin
            dsp_index <= wdata;
        end
    end

    for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_tgt
        // Target byte of timer i.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tmr_target[i*8 +: 8] <= '0;
            end else if (page_wr && (lo == 4'(OFS_TGT0 + i))) begin
                tmr_target[i*8 +: 8] <= wdata;
            end
        end
    end
endmodule

// File: rtl/sio_port_bank.sv
// Mailbox bytes (host-written, processor-read) plus spare bytes, and the
// host-facing bytes written by the processor.
// Assumes N_HOST = 4, so the clear pair bits cover bytes 0-1 and 2-3.
module sio_port_bank
    import sio_pkg::*;
#(
    parameter int N_HOST  = 4,
    parameter int N_EXTRA = 2,
    localparam int N_IN   = N_HOST + N_EXTRA,
    localparam int SEL_W  = $clog2(N_HOST)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cpu_wr,
    input  logic                  page_hit,
    input  logic [3:0]            lo,
    input  logic [DATA_W-1:0]     wdata,
    input  logic                  host_wr,
    input  logic [SEL_W-1:0]      host_sel,
    input  logic [DATA_W-1:0]     host_wdata,
    input  logic                  clr_lo,
    input  logic                  clr_hi,
    output logic [N_IN*8-1:0]     in_bytes,
    output logic [N_HOST*8-1:0]   out_bytes
);
    for (genvar k = 0; k < N_IN; k++) begin : g_in
        logic clr_k;
        logic load_k;
        logic [DATA_W-1:0] src_k;
        if (k < N_HOST) begin : g_host
            assign clr_k  = (k < N_HOST / 2) ? clr_lo : clr_hi;
            assign load_k = host_wr && (host_sel == SEL_W'(k));
            assign src_k  = host_wdata;
        end else begin : g_spare
            assign clr_k  = 1'b0;
            assign load_k = cpu_wr && page_hit && (lo == 4'(OFS_PORT0 + k));
            assign src_k  = wdata;
        end
        // Input byte k: clear has priority over a load.
        always_ff @(posedge clk) begin
            if (!rst_n || clr_k) begin
                in_bytes[k*8 +: 8] <= '0;
            end else if (load_k) begin
                in_bytes[k*8 +: 8] <= src_k;
            end
        end
    end

    for (genvar k = 0; k < N_HOST; k++) begin : g_out
        // Host-facing byte k.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_bytes[k*8 +: 8] <= '0;
            end else if (cpu_wr && page_hit && (lo == 4'(OFS_PORT0 + k))) begin
                out_bytes[k*8 +: 8] <= wdata;
            end
        end
    end
endmodule

// File: rtl/sio_read_path.sv
// Read selection: control page, boot overlay or memory, registered so all
// sources share one cycle of latency. Also produces counter clear pulses.
// Assumes ROM_BYTES is a power of two and the memory returns data one
// cycle after its read enable, holding it until the next read.
module sio_read_path
    import sio_pkg::*;
#(
    parameter int NUM_TIMERS = 3,
    parameter int CNT_W      = 4,
    parameter int N_IN       = 6,
    parameter int ROM_BYTES  = 64,
    parameter logic [ROM_BYTES*8-1:0] ROM_IMAGE = '0,
    localparam int ROM_AW    = $clog2(ROM_BYTES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rd,
    input  logic                        page_hit,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [DATA_W-1:0]           dsp_index,
    input  logic [DATA_W-1:0]           dsp_rdata,
    input  logic [N_IN*8-1:0]           in_bytes,
    input  logic [NUM_TIMERS*CNT_W-1:0] tmr_count_in,
    input  logic                        rom_mapped,
    input  logic [DATA_W-1:0]           ram_rdata,
    output logic [DATA_W-1:0]           cpu_rdata,
    output logic [NUM_TIMERS-1:0]       tmr_count_clr
);
    logic              rom_hit;
    logic              use_ram;
    logic [DATA_W-1:0] local_val;
    logic              use_ram_q;
    logic [DATA_W-1:0] local_q;

    assign rom_hit = &addr[ADDR_W-1:ROM_AW];

    // Source selection for the current request.
    always_comb begin
        use_ram   = 1'b1;
        local_val = '0;
        if (page_hit) begin
            use_ram = 1'b0;
            if (addr[3:0] == OFS_DSP_IDX)  local_val = dsp_index;
            if (addr[3:0] == OFS_DSP_DATA) local_val = dsp_rdata;
            for (int k = 0; k < N_IN; k++) begin
                if (addr[3:0] == 4'(OFS_PORT0 + k)) local_val = in_bytes[k*8 +: 8];
            end
            for (int i = 0; i < NUM_TIMERS; i++) begin
                if (addr[3:0] == 4'(OFS_CNT0 + i)) local_val = 8'(tmr_count_in[i*CNT_W +: CNT_W]);
            end
        end else if (rom_hit && rom_mapped) begin
            use_ram   = 1'b0;
            local_val = ROM_IMAGE[int'(addr[ROM_AW-1:0])*8 +: 8];
        end
    end

    for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_clr
        assign tmr_count_clr[i] = rd && page_hit && (addr[3:0] == 4'(OFS_CNT0 + i));
    end

    // Capture the selection and local value on each read request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            use_ram_q <= 1'b0;
            local_q   <= '0;
        end else if (rd) begin
            use_ram_q <= use_ram;
            local_q   <= local_val;
        end
    end

    assign cpu_rdata = use_ram_q ? ram_rdata : local_q;
endmodule

// File: rtl/sio_io_decoder.sv
// Top: control-page decoder with boot overlay and memory write-through.
// Assumes cpu_rd and cpu_wr are never high in the same cycle.
module sio_io_decoder
    import sio_pkg::*;
#(
    parameter int NUM_TIMERS = 3,
    parameter int CNT_W      = 4,
    parameter int ROM_BYTES  = ROM_BYTES_DEF,
    parameter logic [ROM_BYTES*8-1:0] ROM_IMAGE = rom_default(),
    localparam int N_HOST    = 4,
    localparam int N_EXTRA   = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [15:0]                 cpu_addr,
    input  logic                        cpu_rd,
    input  logic                        cpu_wr,
    input  logic [7:0]                  cpu_wdata,
    output logic [7:0]                  cpu_rdata,
    input  logic                        host_wr,
    input  logic [1:0]                  host_sel,
    input  logic [7:0]                  host_wdata,
    output logic [N_HOST*8-1:0]         host_rx,
    output logic [15:0]                 ram_addr,
    output logic                        ram_re,
    output logic                        ram_we,
    output logic [7:0]                  ram_wdata,
    input  logic [7:0]                  ram_rdata,
    output logic [6:0]                  dsp_idx,
    output logic                        dsp_we,
    output logic [7:0]                  dsp_wdata,
    input  logic [7:0]                  dsp_rdata,
    output logic [NUM_TIMERS-1:0]       tmr_enable,
    output logic [NUM_TIMERS-1:0]       tmr_restart,
    output logic [NUM_TIMERS*8-1:0]     tmr_target,
    input  logic [NUM_TIMERS*CNT_W-1:0] tmr_count_in,
    output logic [NUM_TIMERS-1:0]       tmr_count_clr
);
    logic                          page_hit;
    logic [DATA_W-1:0]             dsp_index;
    logic                          rom_mapped;
    logic                          clr_lo;
    logic                          clr_hi;
    logic [(N_HOST+N_EXTRA)*8-1:0] in_bytes;

    assign page_hit  = (cpu_addr[ADDR_W-1:4] == PAGE_TAG);
    // Every access is forwarded to memory; writes are never absorbed.
    assign ram_addr  = cpu_addr;
    assign ram_re    = cpu_rd;
    assign ram_we    = cpu_wr;
    assign ram_wdata = cpu_wdata;
    assign dsp_idx   = dsp_index[6:0];
    assign dsp_wdata = cpu_wdata;

    sio_ctrl_regs #(.NUM_TIMERS(NUM_TIMERS)) i_ctrl (
        .clk, .rst_n, .wr(cpu_wr), .page_hit, .lo(cpu_addr[3:0]), .wdata(cpu_wdata),
        .tmr_enable, .tmr_restart, .tmr_target, .dsp_index, .dsp_we,
        .rom_mapped, .clr_lo, .clr_hi
    );

    sio_port_bank #(.N_HOST(N_HOST), .N_EXTRA(N_EXTRA)) i_ports (
        .clk, .rst_n, .cpu_wr, .page_hit, .lo(cpu_addr[3:0]), .wdata(cpu_wdata),
        .host_wr, .host_sel, .host_wdata, .clr_lo, .clr_hi,
        .in_bytes, .out_bytes(host_rx)
    );

    sio_read_path #(
        .NUM_TIMERS(NUM_TIMERS), .CNT_W(CNT_W), .N_IN(N_HOST + N_EXTRA),
        .ROM_BYTES(ROM_BYTES), .ROM_IMAGE(ROM_IMAGE)
    ) i_read (
        .clk, .rst_n, .rd(cpu_rd), .page_hit, .addr(cpu_addr), .dsp_index,
        .dsp_rdata, .in_bytes, .tmr_count_in, .rom_mapped, .ram_rdata,
        .cpu_rdata, .tmr_count_clr
    );
endmodule

// File: rtl/sio_io_checker.sv
// Checker: port-level properties of the decoder, bound to every instance.
// Keeps its own copy of the indirect index, rebuilt from observed writes.
module sio_io_checker #(
    parameter int NUM_TIMERS = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [15:0]             cpu_addr,
    input logic                    cpu_rd,
    input logic                    cpu_wr,
    input logic [7:0]              cpu_wdata,
    input logic [7:0]              cpu_rdata,
    input logic [15:0]             ram_addr,
    input logic                    ram_we,
    input logic [7:0]              ram_wdata,
    input logic                    dsp_we,
    input logic [NUM_TIMERS-1:0]   tmr_enable,
    input logic [NUM_TIMERS-1:0]   tmr_restart,
    input logic [NUM_TIMERS*8-1:0] tmr_target,
    input logic [NUM_TIMERS-1:0]   tmr_count_clr
);
    logic [7:0] idx_shadow;
    logic       zero_addr;

    assign zero_addr = (cpu_addr == 16'h00F0) || (cpu_addr == 16'h00F1) ||
                       (cpu_addr == 16'h00FA) || (cpu_addr == 16'h00FB) ||
                       (cpu_addr == 16'h00FC);

    // Shadow of the indirect index from observed writes.
    always_ff @(posedge clk) begin
        if (!rst_n) idx_shadow <= '0;
        else if (cpu_wr && cpu_addr == 16'h00F2) idx_shadow <= cpu_wdata;
    end

    AST_WRITE_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr |-> (ram_we && ram_addr == cpu_addr && ram_wdata == cpu_wdata)); // R2
    AST_ZERO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && zero_addr) |=> (cpu_rdata == 8'h00)); // R4
    AST_INDEX_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_addr == 16'h00F2) |=> (cpu_rdata == $past(idx_shadow))); // R5
    AST_DSP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        dsp_we |-> (cpu_wr && !idx_shadow[7])); // R6
    AST_ENABLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == 16'h00F1) |=> (tmr_enable == $past(cpu_wdata[NUM_TIMERS-1:0]))); // R9
    AST_RESTART_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_restart != '0) |=> ((tmr_enable & $past(tmr_restart)) == $past(tmr_restart))); // R9
    AST_TARGET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_wr |=> $stable(tmr_target)); // R11
    AST_CLEAR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tmr_count_clr)); // R12
    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_count_clr != '0) |-> cpu_rd); // R12
endmodule

bind sio_io_decoder sio_io_checker #(.NUM_TIMERS(NUM_TIMERS)) i_chk (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .ram_addr(ram_addr), .ram_we(ram_we),
    .ram_wdata(ram_wdata), .dsp_we(dsp_we), .tmr_enable(tmr_enable),
    .tmr_restart(tmr_restart), .tmr_target(tmr_target), .tmr_count_clr(tmr_count_clr)
);

// File: tb/test_sio_io_decoder.sv
// Directed bench: one task per scenario, each checking its own results.
module test_sio_io_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        host_wr = 1'b0;
    logic [1:0]  host_sel = '0;
    logic [7:0]  host_wdata = '0;
    logic [31:0] host_rx;
    logic [15:0] ram_addr;
    logic        ram_re;
    logic        ram_we;
    logic [7:0]  ram_wdata;
    logic [7:0]  ram_rdata = '0;
    logic [6:0]  dsp_idx;
    logic        dsp_we;
    logic [7:0]  dsp_wdata;
    logic [7:0]  dsp_rdata;
    logic [2:0]  tmr_enable;
    logic [2:0]  tmr_restart;
    logic [23:0] tmr_target;
    logic [11:0] tmr_count_in = '0;
    logic [2:0]  tmr_count_clr;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;
    // Snapshots taken inside the request cycle.
    logic        s_ram_we, s_dsp_we;
    logic [15:0] s_ram_addr;
    logic [7:0]  s_ram_wdata, s_dsp_wdata;
    logic [2:0]  s_restart, s_clr;

    always #2 clk = ~clk;

    sio_io_decoder i_sio_io_decoder (.*);

    function automatic logic [7:0] ram_fn(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction
    function automatic logic [7:0] rom_fn(input int k);
        return 8'((k * 37 + 17) % 256);
    endfunction
    assign dsp_rdata = {1'b0, dsp_idx} ^ 8'h5A;

    // Memory model: one-cycle read latency, holds data between reads.
    always_ff @(posedge clk) if (ram_re) ram_rdata <= ram_fn(ram_addr);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        #1;
        s_ram_we = ram_we; s_ram_addr = ram_addr; s_ram_wdata = ram_wdata;
        s_dsp_we = dsp_we; s_dsp_wdata = dsp_wdata; s_restart = tmr_restart;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic cpu_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1;
        #1;
        s_clr = tmr_count_clr;
        @(negedge clk);
        cpu_rd = 1'b0;
        d = cpu_rdata;
    endtask

    task automatic host_write(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        host_sel = sel; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check(cpu_rdata == 8'h00, "R1 rdata", cpu_rdata, 0);
        check(tmr_enable == 3'b000 && tmr_target == '0, "R1 timers", tmr_target, 0);
        check(host_rx == '0, "R1 host_rx", host_rx, 0);
        cpu_read(16'h00F2, d);
        check(d == 8'h00, "R1 index", d, 0);
        cpu_read(16'h00F6, d);
        check(d == 8'h00, "R1 mailbox", d, 0);
        cpu_read(16'hFFC0, d);
        check(d == rom_fn(0), "R1 R10 overlay mapped", d, rom_fn(0));
    endtask

    task automatic t_write_through();
        cpu_write(16'h1234, 8'h9E);
        check(s_ram_we && s_ram_addr == 16'h1234 && s_ram_wdata == 8'h9E, "R2 plain", s_ram_wdata, 8'h9E);
        cpu_write(16'h00F5, 8'h61);
        check(s_ram_we && s_ram_addr == 16'h00F5 && s_ram_wdata == 8'h61, "R2 page", s_ram_addr, 16'h00F5);
        cpu_write(16'hFFC3, 8'h44);
        check(s_ram_we && s_ram_addr == 16'hFFC3 && s_ram_wdata == 8'h44, "R2 rom window", s_ram_addr, 16'hFFC3);
    endtask

    task automatic t_zero_reads();
        logic [7:0] d;
        cpu_write(16'h00FA, 8'h77);
        cpu_write(16'h00F1, 8'h83);
        foreach (d[i]) ;
        cpu_read(16'h00F0, d); check(d == 0, "R4 F0", d, 0);
        cpu_read(16'h00F1, d); check(d == 0, "R4 F1", d, 0);
        cpu_read(16'h00FA, d); check(d == 0, "R4 FA", d, 0);
        cpu_read(16'h00FB, d); check(d == 0, "R4 FB", d, 0);
        cpu_read(16'h00FC, d); check(d == 0, "R4 FC", d, 0);
        cpu_write(16'h00F1, 8'h80);
    endtask

    task automatic t_dsp();
        logic [7:0] d;
        cpu_write(16'h00F2, 8'h25);
        cpu_read(16'h00F2, d);
        check(d == 8'h25, "R5 index readback", d, 8'h25);
        check(dsp_idx == 7'h25, "R5 dsp_idx", dsp_idx, 7'h25);
        cpu_read(16'h00F3, d);
        check(d == (8'h25 ^ 8'h5A), "R5 data read", d, 8'h25 ^ 8'h5A);
        cpu_write(16'h00F3, 8'h77);
        check(s_dsp_we && s_dsp_wdata == 8'h77, "R6 write allowed", s_dsp_we, 1);
        cpu_write(16'h00F2, 8'hB1);
        check(dsp_idx == 7'h31, "R5 masked index", dsp_idx, 7'h31);
        cpu_write(16'h00F3, 8'h12);
        check(!s_dsp_we, "R6 write dropped", s_dsp_we, 0);
        check(s_ram_we && s_ram_wdata == 8'h12, "R6 R2 still to memory", s_ram_wdata, 8'h12);
        cpu_read(16'h00F3, d);
        check(d == (8'h31 ^ 8'h5A), "R5 upper-half read", d, 8'h31 ^ 8'h5A);
    endtask

    task automatic t_mailbox();
        logic [7:0] d;
        for (int k = 0; k < 4; k++) host_write(2'(k), 8'hA0 + 8'(k));
        for (int k = 0; k < 4; k++) begin
            cpu_read(16'h00F4 + 16'(k), d);
            check(d == 8'hA0 + 8'(k), "R7 mailbox read", d, 8'hA0 + 8'(k));
        end
        for (int k = 0; k < 4; k++) cpu_write(16'h00F4 + 16'(k), 8'h50 + 8'(k));
        check(host_rx == 32'h53525150, "R7 host_rx", host_rx, 32'h53525150);
        cpu_read(16'h00F4, d);
        check(d == 8'hA0, "R7 mailbox untouched by write", d, 8'hA0);
    endtask

    task automatic t_spare();
        logic [7:0] d;
        cpu_write(16'h00F8, 8'hC8);
        cpu_write(16'h00F9, 8'h9D);
        cpu_read(16'h00F8, d); check(d == 8'hC8, "R8 F8", d, 8'hC8);
        cpu_read(16'h00F9, d); check(d == 8'h9D, "R8 F9", d, 8'h9D);
    endtask

    task automatic t_control();
        logic [7:0] d;
        cpu_write(16'h00F1, 8'h95);
        check(s_restart == 3'b101, "R9 restart pulse", s_restart, 3'b101);
        check(tmr_enable == 3'b101, "R9 enables", tmr_enable, 3'b101);
        cpu_read(16'h00F4, d); check(d == 0, "R9 clear lo p0", d, 0);
        cpu_read(16'h00F5, d); check(d == 0, "R9 clear lo p1", d, 0);
        cpu_read(16'h00F6, d); check(d == 8'hA2, "R9 hi kept", d, 8'hA2);
        // Host write to byte 2 collides with the upper clear.
        @(negedge clk);
        cpu_addr = 16'h00F1; cpu_wdata = 8'hA7; cpu_wr = 1'b1;
        host_sel = 2'd2; host_wdata = 8'hEE; host_wr = 1'b1;
        #1;
        s_restart = tmr_restart;
        @(negedge clk);
        cpu_wr = 1'b0; host_wr = 1'b0;
        check(s_restart == 3'b010, "R9 restart only new", s_restart, 3'b010);
        check(tmr_enable == 3'b111, "R9 enables all", tmr_enable, 3'b111);
        cpu_read(16'h00F6, d); check(d == 0, "R9 clear wins", d, 0);
        cpu_read(16'h00F7, d); check(d == 0, "R9 clear hi p3", d, 0);
    endtask

    task automatic t_overlay();
        logic [7:0] d;
        cpu_read(16'hFFFF, d);
        check(d == rom_fn(63), "R10 last rom byte", d, rom_fn(63));
        cpu_read(16'hFFD7, d);
        check(d == rom_fn(23), "R10 mid rom byte", d, rom_fn(23));
        cpu_write(16'h00F1, 8'h07);
        cpu_read(16'hFFC5, d);
        check(d == ram_fn(16'hFFC5), "R10 unmapped reads memory", d, ram_fn(16'hFFC5));
        cpu_write(16'h00F1, 8'h87);
        cpu_read(16'hFFC5, d);
        check(d == rom_fn(5), "R10 remapped", d, rom_fn(5));
    endtask

    task automatic t_targets();
        cpu_write(16'h00FA, 8'h11);
        cpu_write(16'h00FB, 8'h22);
        cpu_write(16'h00FC, 8'h33);
        check(tmr_target == 24'h332211, "R11 targets", tmr_target, 24'h332211);
        cpu_write(16'h00FD, 8'h99);
        cpu_write(16'h00F9, 8'h98);
        check(tmr_target == 24'h332211, "R11 other writes", tmr_target, 24'h332211);
    endtask

    task automatic t_counters();
        logic [7:0] d;
        tmr_count_in = 12'hA53;
        cpu_read(16'h00FD, d);
        check(d == 8'h03 && s_clr == 3'b001, "R12 counter 0", d, 8'h03);
        cpu_read(16'h00FE, d);
        check(d == 8'h05 && s_clr == 3'b010, "R12 counter 1", d, 8'h05);
        cpu_read(16'h00FF, d);
        check(d == 8'h0A && s_clr == 3'b100, "R12 counter 2", d, 8'h0A);
        cpu_read(16'h00FC, d);
        check(s_clr == 3'b000, "R12 no clear elsewhere", s_clr, 0);
    endtask

    task automatic t_memory();
        logic [7:0] d;
        cpu_read(16'h0100, d);
        check(d == ram_fn(16'h0100), "R13 0100", d, ram_fn(16'h0100));
        cpu_read(16'h00EF, d);
        check(d == ram_fn(16'h00EF), "R13 below page", d, ram_fn(16'h00EF));
        cpu_read(16'hFFBF, d);
        check(d == ram_fn(16'hFFBF), "R13 below overlay", d, ram_fn(16'hFFBF));
        @(negedge clk);
        @(negedge clk);
        check(cpu_rdata == ram_fn(16'hFFBF), "R3 data held", cpu_rdata, ram_fn(16'hFFBF));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write_through();
        t_zero_reads();
        t_dsp();
        t_mailbox();
        t_spare();
        t_control();
        t_overlay();
        t_targets();
        t_counters();
        t_memory();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            vectors++;
            fails++;
            $display("FAIL all requirements: watchdog expired, actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule